// File: doc/BRIEF.md
# Pipelined Fixed-Point Square Root

This block takes an unsigned binary integer operand and returns its square root as an unsigned fixed-point number. By default the operand is 64 bits wide. The result has 32 integer bits and 4 fraction bits, 36 bits in all. The result is truncated, never rounded. To produce the fraction bits, the block extends the operand with eight zero bits below its least significant bit. It then runs an integer shift-and-subtract root on the widened value. Each trial subtraction decides one result bit, starting from the most significant one.

The recurrence is fully unrolled. Its 36 steps are spread as evenly as possible over five register stages (7, 7, 7, 7 and 8 steps). A new operand can therefore enter on every clock. Each result leaves the block a fixed five clocks after its operand.

A valid flag travels with the data through every stage. The stream has no back-pressure: the block accepts every operand that is flagged valid. The downstream logic must take each result in the one cycle in which `out_valid` is high.

Top module: `fxp_sqrt_pipe`

## Requirements
- R1: When `out_valid` is high, `out_root` holds the largest R for which R*R does not exceed (operand * 256). In other words, it is the truncated root in unsigned 32.4 format: bits [35:4] are the integer part and bits [3:0] are the fraction.
- R2: An operand accepted in a cycle with `in_valid` high gives `out_valid` high exactly 5 cycles later, together with that operand's root.
- R3: Operands presented on consecutive cycles give results on consecutive cycles, in the same order, with no cycle lost.
- R4: A cycle with `in_valid` low is ignored whatever `in_data` holds. Five cycles later `out_valid` is low, so idle gaps in the input reappear unchanged at the output.
- R5: While the synchronous reset `rst` is sampled high, every in-flight valid flag is cleared. `out_valid` is low in the cycle after each reset edge, and it stays low until a new valid operand has passed through the pipeline. Operands that were in flight at reset never appear.
- R6: Boundary values, written as hex results:

  | Operand | Result |
  |---|---|
  | 0 | 0x0 |
  | 1 | 0x10 |
  | 2^62 | 0x800000000 |
  | 2^64-1 | 0xFFFFFFFFF |

- R7: The widths follow the parameters: the result is IN_W/2 + FRAC_W bits wide and the latency is STAGES cycles. A 12-bit operand with 4 fraction bits meets R1 for every one of its 4096 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; clears valid flags only |
| in_valid | input | 1 | Operand on `in_data` is accepted this cycle |
| in_data | input | IN_W (64) | Unsigned integer operand |
| out_valid | output | 1 | `out_root` carries a result this cycle |
| out_root | output | IN_W/2+FRAC_W (36) | Truncated root, unsigned 32.4 fixed point |

## Verification
Every result is due exactly five cycles after the clock edge that accepted its operand. The bench records that due cycle with each operand it drives. On each falling edge it requires `out_valid` to be high only when the oldest outstanding operand is due. A result that arrives early, late, out of order or without a matching operand is therefore reported. The value checks compare the root against a binary-search reference and against the bounds R*R ≤ operand*256 < (R+1)^2. They cover corner operands, back-to-back random streams, streams with idle gaps, a reset in mid-stream, and an exhaustive sweep of a 12-bit configuration.

// File: rtl/fxp_sqrt_pkg.sv
package fxp_sqrt_pkg;

  // Index of the first recurrence step handled by stage s when `total`
  // steps are spread over `stages` register stages.
  function automatic int step_base(input int s, input int total, input int stages);
    return (s * total) / stages;
  endfunction

  // Number of recurrence steps inside stage s.
  function automatic int steps_in(input int s, input int total, input int stages);
    return step_base(s + 1, total, stages) - step_base(s, total, stages);
  endfunction

endpackage

// File: rtl/fxp_sqrt_step.sv
// One trial-subtract step: consume two operand bits, decide one root bit.
module fxp_sqrt_step #(
  parameter int PAD_W = 72,
  parameter int RT_W  = 36
) (
  input  logic [RT_W-1:0]  root_i,
  input  logic [RT_W+1:0]  rem_i,
  input  logic [PAD_W-1:0] op_i,
  output logic [RT_W-1:0]  root_o,
  output logic [RT_W+1:0]  rem_o,
  output logic [PAD_W-1:0] op_o
);
  localparam int REM_W = RT_W + 2;
  localparam int TW    = REM_W + 2;

  logic [TW-1:0] rem_t;
  logic [TW-1:0] trial;
  logic [TW:0]   diff;
  logic          fits;

  // bring down the next pair of operand bits
  assign rem_t = {rem_i, op_i[PAD_W-1:PAD_W-2]};
  // trial value is 4*root + 1
  assign trial = {2'b00, root_i, 2'b01};
  assign diff  = {1'b0, rem_t} - {1'b0, trial};
  assign fits  = ~diff[TW];

  // the kept remainder never exceeds 2*root, so REM_W bits hold it
  assign rem_o  = fits ? diff[REM_W-1:0] : rem_t[REM_W-1:0];
  assign root_o = {root_i[RT_W-2:0], fits};
  assign op_o   = {op_i[PAD_W-3:0], 2'b00};

  logic unused_hi;
  assign unused_hi = ^{rem_t[TW-1:REM_W], diff[TW-1:REM_W], root_i[RT_W-1]};
endmodule

// File: rtl/fxp_sqrt_stage.sv
// A group of unrolled steps followed by one register boundary.
module fxp_sqrt_stage #(
  parameter int PAD_W   = 72,
  parameter int RT_W    = 36,
  parameter int N_STEPS = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic [RT_W-1:0]  root_i,
  input  logic [RT_W+1:0]  rem_i,
  input  logic [PAD_W-1:0] op_i,
  output logic             vld_o,
  output logic [RT_W-1:0]  root_o,
  output logic [RT_W+1:0]  rem_o,
  output logic [PAD_W-1:0] op_o
);
  logic [RT_W-1:0]  root_c [N_STEPS+1];
  logic [RT_W+1:0]  rem_c  [N_STEPS+1];
  logic [PAD_W-1:0] op_c   [N_STEPS+1];

  assign root_c[0] = root_i;
  assign rem_c[0]  = rem_i;
  assign op_c[0]   = op_i;

  for (genvar k = 0; k < N_STEPS; k++) begin : g_step
    fxp_sqrt_step #(.PAD_W(PAD_W), .RT_W(RT_W)) step_i (
      .root_i (root_c[k]),
      .rem_i  (rem_c[k]),
      .op_i   (op_c[k]),
      .root_o (root_c[k+1]),
      .rem_o  (rem_c[k+1]),
      .op_o   (op_c[k+1])
    );
  end

  // valid is reset; the data registers are not
  always_ff @(posedge clk) begin
    if (rst) vld_o <= 1'b0;
    else     vld_o <= vld_i;
  end

  always_ff @(posedge clk) begin
    root_o <= root_c[N_STEPS];
    rem_o  <= rem_c[N_STEPS];
    op_o   <= op_c[N_STEPS];
  end
endmodule

// File: rtl/fxp_sqrt_pipe.sv
// Fully unrolled, pipelined truncated square root, unsigned integer in,
// unsigned fixed point (IN_W/2 integer bits, FRAC_W fraction bits) out.
module fxp_sqrt_pipe #(
  parameter int IN_W   = 64,
  parameter int FRAC_W = 4,
  parameter int STAGES = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [IN_W-1:0]          in_data,
  output logic                     out_valid,
  output logic [IN_W/2+FRAC_W-1:0] out_root
);
  import fxp_sqrt_pkg::*;

  localparam int PAD_W = IN_W + 2 * FRAC_W;  // operand widened by zero padding
  localparam int RT_W  = PAD_W / 2;          // one root bit per operand pair
  localparam int REM_W = RT_W + 2;

  logic             vld_p  [STAGES+1];
  logic [RT_W-1:0]  root_p [STAGES+1];
  logic [REM_W-1:0] rem_p  [STAGES+1];
  logic [PAD_W-1:0] op_p   [STAGES+1];

  assign vld_p[0]  = in_valid;
  assign root_p[0] = '0;
  assign rem_p[0]  = '0;
  assign op_p[0]   = {in_data, {(2*FRAC_W){1'b0}}};

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int NS = steps_in(s, RT_W, STAGES);
    fxp_sqrt_stage #(.PAD_W(PAD_W), .RT_W(RT_W), .N_STEPS(NS)) stage_i (
      .clk    (clk),
      .rst    (rst),
      .vld_i  (vld_p[s]),
      .root_i (root_p[s]),
      .rem_i  (rem_p[s]),
      .op_i   (op_p[s]),
      .vld_o  (vld_p[s+1]),
      .root_o (root_p[s+1]),
      .rem_o  (rem_p[s+1]),
      .op_o   (op_p[s+1])
    );
  end

  assign out_valid = vld_p[STAGES];
  assign out_root  = root_p[STAGES];

  logic unused_tail;
  assign unused_tail = ^{rem_p[STAGES], op_p[STAGES]};
endmodule

// File: rtl/fxp_sqrt_pipe_chk.sv
module fxp_sqrt_pipe_chk #(
  parameter int IN_W   = 64,
  parameter int FRAC_W = 4,
  parameter int STAGES = 5
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic [IN_W-1:0]          in_data,
  input logic                     out_valid,
  input logic [IN_W/2+FRAC_W-1:0] out_root
);
  localparam int PAD_W = IN_W + 2 * FRAC_W;
  localparam int RT_W  = PAD_W / 2;

  logic [STAGES-1:0] v_hist;
  logic [IN_W-1:0]   d_hist [STAGES];

  always_ff @(posedge clk) begin
    if (rst) v_hist <= '0;
    else     v_hist <= {v_hist[STAGES-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    d_hist[0] <= in_data;
    for (int i = 1; i < STAGES; i++) d_hist[i] <= d_hist[i-1];
  end

  logic [PAD_W+1:0] padded, sq_lo, sq_hi;
  always_comb begin
    padded = {2'b00, d_hist[STAGES-1], {(2*FRAC_W){1'b0}}};
    sq_lo  = {2'b00, out_root} * {2'b00, out_root};
    sq_hi  = ({2'b00, out_root} + 1'b1) * ({2'b00, out_root} + 1'b1);
  end

  // R2 R4
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == v_hist[STAGES-1]);

  // R1
  root_floor_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (sq_lo <= padded) && (sq_hi > padded));

  // R1
  root_known_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$isunknown(out_root));

  // R5
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !out_valid);

  logic unused_w;
  assign unused_w = ^{RT_W[0]};
endmodule

bind fxp_sqrt_pipe fxp_sqrt_pipe_chk #(
  .IN_W(IN_W), .FRAC_W(FRAC_W), .STAGES(STAGES)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_root(out_root)
);

// File: tb/fxp_sqrt_pipe_tb_top.sv
`timescale 1ns/1ps
module fxp_sqrt_pipe_tb_top;
  localparam int LAT = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        b_in_valid = 1'b0;
  logic [63:0] b_in_data = '0;
  logic        b_out_valid;
  logic [35:0] b_out_root;
  logic        s_in_valid = 1'b0;
  logic [11:0] s_in_data = '0;
  logic        s_out_valid;
  logic [9:0]  s_out_root;

  always #4 clk = ~clk;  // 125 MHz

  fxp_sqrt_pipe dut_i (
    .clk(clk), .rst(rst), .in_valid(b_in_valid), .in_data(b_in_data),
    .out_valid(b_out_valid), .out_root(b_out_root));

  fxp_sqrt_pipe #(.IN_W(12), .FRAC_W(4), .STAGES(5)) dut_small_i (
    .clk(clk), .rst(rst), .in_valid(s_in_valid), .in_data(s_in_data),
    .out_valid(s_out_valid), .out_root(s_out_root));

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit mon_on = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [35:0] ref_big(input logic [63:0] x);
    logic [79:0] v, lo, hi, mid;
    v = {8'h00, x, 8'h00}; lo = 0; hi = 80'd1 << 36;
    while (hi - lo > 1) begin
      mid = (lo + hi) >> 1;
      if (mid * mid <= v) lo = mid; else hi = mid;
    end
    return lo[35:0];
  endfunction

  function automatic logic [9:0] ref_small(input logic [11:0] x);
    logic [31:0] v, lo, hi, mid;
    v = {12'h000, x, 8'h00}; lo = 0; hi = 32'd1 << 10;
    while (hi - lo > 1) begin
      mid = (lo + hi) >> 1;
      if (mid * mid <= v) lo = mid; else hi = mid;
    end
    return lo[9:0];
  endfunction

  // outstanding operands: value and the cycle their result is due
  logic [63:0] bq_d [16]; int bq_due [16]; int bq_wr = 0, bq_rd = 0;
  logic [11:0] sq_d [16]; int sq_due [16]; int sq_wr = 0, sq_rd = 0;

  task automatic send_big(input bit v, input logic [63:0] d);
    @(negedge clk);
    b_in_valid = v; b_in_data = d;
    if (v) begin bq_d[bq_wr%16] = d; bq_due[bq_wr%16] = cyc + LAT; bq_wr++; end
  endtask

  task automatic send_small(input bit v, input logic [11:0] d);
    @(negedge clk);
    s_in_valid = v; s_in_data = d;
    if (v) begin sq_d[sq_wr%16] = d; sq_due[sq_wr%16] = cyc + LAT; sq_wr++; end
  endtask

  // 64-bit monitor: R2 R3 R4 timing, R1 value, R6 corners
  always @(negedge clk) begin
    #1;
    if (mon_on) begin : mon_big
      bit due_now;
      logic [63:0] d; logic [79:0] v, r, lo2, hi2;
      due_now = (bq_rd != bq_wr) && (bq_due[bq_rd%16] == cyc);
      check(b_out_valid == due_now, "R2", "out_valid vs due", 80'(b_out_valid), 80'(due_now));
      if (b_out_valid && due_now) begin
        d = bq_d[bq_rd%16]; bq_rd++;
        v = {8'h00, d, 8'h00}; r = {44'h0, b_out_root};
        lo2 = r * r; hi2 = (r + 1) * (r + 1);
        check(lo2 <= v && hi2 > v, "R1", "floor bounds", r, 80'(ref_big(d)));
        check(b_out_root == ref_big(d), "R1", "root value", r, 80'(ref_big(d)));
        if (d == 64'd0)        check(b_out_root == 36'h0,         "R6", "zero", r, 80'h0);
        if (d == 64'd1)        check(b_out_root == 36'h10,        "R6", "one", r, 80'h10);
        if (d == 64'd1 << 62)  check(b_out_root == 36'h800000000, "R6", "pow62", r, 80'h800000000);
        if (d == '1)           check(b_out_root == 36'hFFFFFFFFF, "R6", "max", r, 80'hFFFFFFFFF);
      end
    end
  end

  // 12-bit monitor: R7
  always @(negedge clk) begin
    #1;
    if (mon_on) begin : mon_small
      bit due_now;
      logic [11:0] d;
      due_now = (sq_rd != sq_wr) && (sq_due[sq_rd%16] == cyc);
      check(s_out_valid == due_now, "R7", "small out_valid vs due", 80'(s_out_valid), 80'(due_now));
      if (s_out_valid && due_now) begin
        d = sq_d[sq_rd%16]; sq_rd++;
        check(s_out_root == ref_small(d), "R7", "small root", 80'(s_out_root), 80'(ref_small(d)));
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(100000 * 8);
    check(1'b0, "R3", "watchdog expired", 80'(cyc), 80'd0);
    finish_run();
  end

  initial begin
    // R5: valid inputs during reset never come out
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); b_in_valid = 1'b1; b_in_data = 64'hDEAD_BEEF_0000_1234;
      #1 check(!b_out_valid, "R5", "out_valid in reset", 80'(b_out_valid), 80'd0);
    end
    @(negedge clk); rst = 1'b0; b_in_valid = 1'b0;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); #1 check(!b_out_valid, "R5", "out_valid after reset", 80'(b_out_valid), 80'd0);
    end
    mon_on = 1'b1;

    // R6 corners back to back
    send_big(1, 64'd0);              send_big(1, 64'd1);
    send_big(1, 64'd2);              send_big(1, 64'd3);
    send_big(1, 64'd4);              send_big(1, '1);
    send_big(1, 64'hFFFF_FFFF_FFFF_FFFE); send_big(1, 64'd1 << 62);
    send_big(1, 64'hFFFF_FFFE_0000_0001); send_big(1, 64'd1 << 63);
    send_big(1, 64'hFFFF_FFFE_0000_0000); send_big(1, 64'd255);

    // R3: random operands on every clock, various magnitudes
    for (int i = 0; i < 1500; i++)
      send_big(1, {$urandom, $urandom} >> ($urandom % 64));

    // R4: idle gaps with garbage data
    for (int i = 0; i < 600; i++)
      send_big(($urandom % 3) != 0, {$urandom, $urandom});
    for (int i = 0; i < 10; i++) send_big(0, {$urandom, $urandom});

    // R5: reset in mid-stream discards in-flight operands
    send_big(1, 64'd100); send_big(1, 64'd200); send_big(1, 64'd300);
    mon_on = 1'b0;
    @(negedge clk); rst = 1'b1; b_in_valid = 1'b0;
    @(negedge clk); rst = 1'b0; bq_rd = bq_wr;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1 check(!b_out_valid, "R5", "in-flight after reset", 80'(b_out_valid), 80'd0);
    end
    mon_on = 1'b1;

    // R7: exhaustive sweep of the 12-bit configuration
    for (int x = 0; x < 4096; x++) send_small(1, 12'(x));
    send_small(0, 12'h0);
    for (int i = 0; i < 10; i++) send_big(0, 64'd0);
    finish_run();
  end
endmodule